// File: doc/BRIEF.md
# Alias-Tracking Register File with Address Tags

This block is a 32-entry general register file. Sixteen of its registers can also be bound to a memory word address. A compiler can then keep a value that might be reached through a pointer in a register. The block watches the ordinary load and store stream for that address. Binding is done with a tagged load, which writes the loaded word into a register and records its address. Release is done with a tagged store. While a binding is live, an ordinary access to the same address is handled in one of two ways, chosen by a mode input. In forward mode it is served from, or written into, the register. In trap mode it is refused with a trap pulse that names the register.

Forwarded stores set a dirty flag instead of going to memory. A dirty value reaches memory only when its binding ends, as a single write of the register contents to the bound address. Associative search is limited to one set of four entries, selected by the two low address bits. The hardware therefore holds four tag comparators rather than sixteen. The surrounding pipeline drives one tagged or ordinary operation per cycle and consumes the memory request port.

Top module: `alias_tagged_rf`

## Requirements
- R1: The register-number ports behave as a register file with one write port and two read ports. Read data appears on the clock edge after the index is presented, and holds the value from before any write on that same edge.
- R2: Operation codes are 0 = tagged load, 1 = tagged store, 2 = ordinary load, 3 = ordinary store. Registers 0 to 15 are taggable, and register r belongs to set r[1:0]. A tagged load writes `op_data` into `op_reg`. If `op_reg` is taggable and `op_reg[1:0]` equals `op_addr[1:0]`, the register is bound to `op_addr` as valid and clean.
- R3: A tagged store to a bound register ends the binding. A later ordinary access to the old address goes to memory.
- R4: In forward mode (`fwd_mode`=1), an ordinary load that matches a binding gives `ld_hit`=1 and `ld_data` equal to the register, one edge later, with no memory request.
- R5: In forward mode, an ordinary store that matches a binding writes `op_data` into the register, marks it dirty and issues no memory request.
- R6: In trap mode (`fwd_mode`=0), a matching ordinary access gives a one-cycle `trap` pulse with `trap_idx` equal to the register. There is no memory request, and no register or dirty state changes.
- R7: An ordinary access that matches nothing issues a memory request one edge later: `mem_we`=0 for a load, or `mem_we`=1 with `mem_wdata`=`op_data` for a store, with `mem_addr`=`op_addr`.
- R8: When a dirty binding ends, one memory write is issued of the register value to the bound address. Ending a clean binding issues no request.
- R9: Registers 16 to 31, and tagged loads whose register set differs from the address set, never bind. Ordinary accesses to such addresses miss. A set-mismatched tagged load to a taggable register drops its old binding without write-back.
- R10: A tagged load to an address bound to a different register ends that binding, with a write-back if it was dirty. Afterwards only the new register matches.
- R11: A write through the register-number port to a bound register marks it dirty, so the new value is written back on release.
- R12: Synchronous reset clears every binding and dirty flag and all output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_mode | input | 1 | 1 = forward matching accesses, 0 = trap them |
| op_en | input | 1 | Operation valid this cycle |
| op_kind | input | 2 | Operation code (see R2) |
| op_reg | input | 5 | Register number for tagged operations |
| op_addr | input | 32 | Word address |
| op_data | input | 32 | Load data for a tagged load, store data for an ordinary store |
| wr_en | input | 1 | Register-number write enable |
| wr_idx | input | 5 | Register-number write index |
| wr_data | input | 32 | Register-number write data |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| ld_hit | output | 1 | Ordinary load served from a register |
| ld_data | output | 32 | Forwarded load data |
| trap | output | 1 | Trap pulse |
| trap_idx | output | 5 | Register that caused the trap |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory request address |
| mem_wdata | output | 32 | Memory write data |

## Verification
Every result of an operation is registered once. Read data, forwarded load data, trap pulses and memory requests all appear on the first rising edge after the operation is presented. Binding and dirty changes from that same edge are visible to the next operation. The bench presents each operation for exactly one edge, samples 1 ns after that edge, and then removes the operation. Pulse outputs are checked again after one idle edge to confirm they last a single cycle. Internal binding state is observed only through later ordinary accesses, register reads and write-back requests.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    OP_TLOAD  = 2'd0,
    OP_TSTORE = 2'd1,
    OP_LOAD   = 2'd2,
    OP_STORE  = 2'd3
  } arf_op_e;
endpackage

// File: rtl/arf_regs.sv
// Data storage: two registered read ports, one combinational port for
// forwarding / write-back, two write ports (port A wins on same index).
module arf_regs #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic [IW-1:0] rc_idx,
  output logic [DW-1:0] rc_data
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_idx];
    rb_data <= mem[rb_idx];
    if (wb_en) mem[wb_idx] <= wb_data;
    if (wa_en) mem[wa_idx] <= wa_data;
  end

  assign rc_data = mem[rc_idx];
endmodule

// File: rtl/arf_tags.sv
// Tag, valid and dirty state with a set-limited associative compare.
module arf_tags #(
  parameter int NTAG = 16,
  parameter int WAYS = 4,
  parameter int AW   = 32,
  localparam int SETS  = NTAG / WAYS,
  localparam int SET_W = $clog2(SETS),
  localparam int TW    = $clog2(NTAG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [TW-1:0] hit_idx,
  output logic          hit_dirty,
  input  logic [TW-1:0] q_idx,
  output logic          q_valid,
  output logic          q_dirty,
  output logic [AW-1:0] q_tag,
  input  logic          set_en,
  input  logic [TW-1:0] set_idx,
  input  logic [AW-1:0] set_tag,
  input  logic          drop_a_en,
  input  logic [TW-1:0] drop_a_idx,
  input  logic          drop_b_en,
  input  logic [TW-1:0] drop_b_idx,
  input  logic          mark_a_en,
  input  logic [TW-1:0] mark_a_idx,
  input  logic          mark_b_en,
  input  logic [TW-1:0] mark_b_idx
);
  logic [NTAG-1:0] valid_q, dirty_q;
  logic [AW-1:0]   tag_q [NTAG];
  logic [SET_W-1:0] look_set;
  logic [WAYS-1:0]  way_hit;
  logic [TW-1:0]    way_idx [WAYS];

  assign look_set = look_addr[SET_W-1:0];

  // entry index = way * SETS + set, so entry e lives in set e[SET_W-1:0]
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_idx[w] = TW'(w * SETS) + TW'(look_set);
    assign way_hit[w] = valid_q[way_idx[w]] && (tag_q[way_idx[w]] == look_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_idx = way_idx[w];
  end

  assign hit       = |way_hit;
  assign hit_dirty = dirty_q[hit_idx];
  assign q_valid   = valid_q[q_idx];
  assign q_dirty   = dirty_q[q_idx];
  assign q_tag     = tag_q[q_idx];

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int e = 0; e < NTAG; e++) begin
        if (set_en && set_idx == TW'(e)) begin
          valid_q[e] <= 1'b1;
          dirty_q[e] <= 1'b0;
        end else if ((drop_a_en && drop_a_idx == TW'(e)) ||
                     (drop_b_en && drop_b_idx == TW'(e))) begin
          valid_q[e] <= 1'b0;
          dirty_q[e] <= 1'b0;
        end else if (valid_q[e] && ((mark_a_en && mark_a_idx == TW'(e)) ||
                                    (mark_b_en && mark_b_idx == TW'(e)))) begin
          dirty_q[e] <= 1'b1;
        end
      end
    end
  end

  // R10: an address is bound to at most one register
  a_r10_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
  // R12 / R8: a dirty flag never outlives its binding
  a_r8_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/alias_tagged_rf.sv
module alias_tagged_rf
  import arf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NTAG = 16,
  parameter int WAYS = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int RW    = $clog2(NREG),
  localparam int TW    = $clog2(NTAG),
  localparam int SET_W = $clog2(NTAG / WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_mode,
  input  logic          op_en,
  input  logic [1:0]    op_kind,
  input  logic [RW-1:0] op_reg,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [RW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [RW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          trap,
  output logic [RW-1:0] trap_idx,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic is_tl, is_ts, is_ld, is_st;
  logic op_tagged, wr_tagged, set_ok;
  logic [TW-1:0] op_tidx;
  logic hit, hit_dirty, q_valid, q_dirty;
  logic [TW-1:0] hit_idx;
  logic [AW-1:0] q_tag;
  logic displace, release_now, fwd_ld, fwd_st, trap_now, miss_ld, miss_st, wb_now;
  logic wa_en;
  logic [RW-1:0] wa_idx, rc_idx, hit_reg;
  logic [DW-1:0] rc_data;

  assign is_tl = op_en && op_kind == OP_TLOAD;
  assign is_ts = op_en && op_kind == OP_TSTORE;
  assign is_ld = op_en && op_kind == OP_LOAD;
  assign is_st = op_en && op_kind == OP_STORE;

  assign op_tagged = int'(op_reg) < NTAG;
  assign wr_tagged = int'(wr_idx) < NTAG;
  assign op_tidx   = op_reg[TW-1:0];
  assign set_ok    = op_addr[SET_W-1:0] == op_reg[SET_W-1:0];
  assign hit_reg   = RW'(hit_idx);

  arf_tags #(.NTAG(NTAG), .WAYS(WAYS), .AW(AW)) u_tags (
    .clk(clk), .rst(rst),
    .look_addr(op_addr), .hit(hit), .hit_idx(hit_idx), .hit_dirty(hit_dirty),
    .q_idx(op_tidx), .q_valid(q_valid), .q_dirty(q_dirty), .q_tag(q_tag),
    .set_en(is_tl && op_tagged && set_ok), .set_idx(op_tidx), .set_tag(op_addr),
    .drop_a_en((is_tl && op_tagged && !set_ok) || release_now), .drop_a_idx(op_tidx),
    .drop_b_en(displace), .drop_b_idx(hit_idx),
    .mark_a_en(fwd_st), .mark_a_idx(hit_idx),
    .mark_b_en(wr_en && wr_tagged), .mark_b_idx(wr_idx[TW-1:0])
  );

  // decisions for the operation in this cycle
  assign displace    = is_tl && hit && !(op_tagged && hit_idx == op_tidx);
  assign release_now = is_ts && op_tagged && q_valid;
  assign fwd_ld      = is_ld && hit && fwd_mode;
  assign fwd_st      = is_st && hit && fwd_mode;
  assign trap_now    = (is_ld || is_st) && hit && !fwd_mode;
  assign miss_ld     = is_ld && !hit;
  assign miss_st     = is_st && !hit;
  assign wb_now      = (displace && hit_dirty) || (release_now && q_dirty);

  assign wa_en  = is_tl || fwd_st;
  assign wa_idx = is_tl ? op_reg : hit_reg;
  assign rc_idx = release_now ? op_reg : hit_reg;

  arf_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(op_data),
    .wb_en(wr_en), .wb_idx(wr_idx), .wb_data(wr_data),
    .ra_idx(rd_a_idx), .ra_data(rd_a_data),
    .rb_idx(rd_b_idx), .rb_data(rd_b_data),
    .rc_idx(rc_idx), .rc_data(rc_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit    <= 1'b0;
      ld_data   <= '0;
      trap      <= 1'b0;
      trap_idx  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      ld_hit   <= fwd_ld;
      trap     <= trap_now;
      mem_req  <= wb_now || miss_ld || miss_st;
      mem_we   <= wb_now || miss_st;
      if (fwd_ld)   ld_data  <= rc_data;
      if (trap_now) trap_idx <= hit_reg;
      if (wb_now) begin
        mem_addr  <= release_now ? q_tag : op_addr;
        mem_wdata <= rc_data;
      end else if (miss_ld || miss_st) begin
        mem_addr  <= op_addr;
        mem_wdata <= op_data;
      end
    end
  end

  a_r6_trap_alone: assert property (@(posedge clk) disable iff (rst)
    trap |-> !mem_req && !ld_hit);
  a_r6_trap_in_trap_mode: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(!fwd_mode));
  a_r4_hit_no_memory: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> $past(fwd_mode) && !mem_req);
  a_r5_fwd_store_quiet: assert property (@(posedge clk) disable iff (rst)
    fwd_st |=> !mem_req);
  a_r8_clean_release_quiet: assert property (@(posedge clk) disable iff (rst)
    (release_now && !q_dirty) |=> !mem_req);
endmodule

// File: tb/sim_alias_tagged_rf.sv
`timescale 1ns/1ps
module sim_alias_tagged_rf;
  logic        clk = 1'b0;
  logic        rst, fwd_mode, op_en, wr_en;
  logic [1:0]  op_kind;
  logic [4:0]  op_reg, wr_idx, rd_a_idx, rd_b_idx, trap_idx;
  logic [31:0] op_addr, op_data, wr_data, rd_a_data, rd_b_data, ld_data, mem_addr, mem_wdata;
  logic        ld_hit, trap, mem_req, mem_we;
  int nchk = 0, nfail = 0;

  localparam logic [1:0] K_TL = 2'd0, K_TS = 2'd1, K_LD = 2'd2, K_ST = 2'd3;

  always #2.5 clk = ~clk;

  alias_tagged_rf u0 (
    .clk(clk), .rst(rst), .fwd_mode(fwd_mode), .op_en(op_en), .op_kind(op_kind),
    .op_reg(op_reg), .op_addr(op_addr), .op_data(op_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .ld_hit(ld_hit), .ld_data(ld_data), .trap(trap), .trap_idx(trap_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic op(input logic [1:0] k, input logic [4:0] r, input logic [31:0] a, input logic [31:0] d);
    op_en = 1'b1; op_kind = k; op_reg = r; op_addr = a; op_data = d;
    tick();
    op_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] ea,
                        input logic [4:0] b, input logic [31:0] eb);
    rd_a_idx = a; rd_b_idx = b;
    tick();
    chk(req, "rd_a_data", rd_a_data, ea);
    chk(req, "rd_b_data", rd_b_data, eb);
  endtask

  task automatic mem_chk(input string req, input logic r, input logic w,
                         input logic [31:0] a, input logic [31:0] d);
    chk(req, "mem_req", mem_req, r);
    if (r) begin
      chk(req, "mem_we", mem_we, w);
      chk(req, "mem_addr", mem_addr, a);
      if (w) chk(req, "mem_wdata", mem_wdata, d);
    end
  endtask

  task automatic t_reset();
    chk("R12", "ld_hit", ld_hit, 0);
    chk("R12", "trap", trap, 0);
    chk("R12", "mem_req", mem_req, 0);
    op(K_LD, 0, 32'h100, 0);            // nothing bound after reset
    mem_chk("R12", 1, 0, 32'h100, 0);
    chk("R12", "ld_hit", ld_hit, 0);
  endtask

  task automatic t_regport();           // R1
    wr(20, 32'hAAAA);
    wr(3, 32'h1234);
    rd_chk("R1", 20, 32'hAAAA, 3, 32'h1234);
    rd_a_idx = 3; wr_en = 1'b1; wr_idx = 3; wr_data = 32'h5678;
    tick(); wr_en = 1'b0;
    chk("R1", "read-first", rd_a_data, 32'h1234);
    rd_chk("R1", 3, 32'h5678, 20, 32'hAAAA);
  endtask

  task automatic t_forward();           // R2 R4 R5 R8 R3
    fwd_mode = 1'b1;
    op(K_TL, 5, 32'h1001, 32'hCAFE);
    mem_chk("R2", 0, 0, 0, 0);
    op(K_LD, 0, 32'h1001, 0);
    chk("R4", "ld_hit", ld_hit, 1);
    chk("R4", "ld_data", ld_data, 32'hCAFE);
    mem_chk("R4", 0, 0, 0, 0);
    tick();
    chk("R4", "ld_hit pulse", ld_hit, 0);
    rd_chk("R2", 5, 32'hCAFE, 5, 32'hCAFE);
    op(K_ST, 0, 32'h1001, 32'hBEEF);
    mem_chk("R5", 0, 0, 0, 0);
    rd_chk("R5", 5, 32'hBEEF, 5, 32'hBEEF);
    op(K_TS, 5, 0, 0);
    mem_chk("R8", 1, 1, 32'h1001, 32'hBEEF);
    op(K_LD, 0, 32'h1001, 0);
    chk("R3", "ld_hit", ld_hit, 0);
    mem_chk("R3", 1, 0, 32'h1001, 0);
    op(K_TL, 6, 32'h2002, 32'h7);
    op(K_TS, 6, 0, 0);
    mem_chk("R8 clean", 0, 0, 0, 0);
  endtask

  task automatic t_trap();              // R6
    fwd_mode = 1'b0;
    op(K_TL, 7, 32'h3003, 32'h77);
    op(K_LD, 0, 32'h3003, 0);
    chk("R6", "trap", trap, 1);
    chk("R6", "trap_idx", trap_idx, 7);
    chk("R6", "ld_hit", ld_hit, 0);
    mem_chk("R6", 0, 0, 0, 0);
    op(K_ST, 0, 32'h3003, 32'h99);
    chk("R6", "trap on store", trap, 1);
    mem_chk("R6", 0, 0, 0, 0);
    tick();
    chk("R6", "trap pulse", trap, 0);
    rd_chk("R6", 7, 32'h77, 7, 32'h77);
    op(K_TS, 7, 0, 0);
    mem_chk("R6 not dirty", 0, 0, 0, 0);
    fwd_mode = 1'b1;
  endtask

  task automatic t_nobind();            // R9 R7
    op(K_TL, 20, 32'h4000, 32'h5);
    op(K_LD, 0, 32'h4000, 0);
    chk("R9", "untagged ld_hit", ld_hit, 0);
    mem_chk("R9", 1, 0, 32'h4000, 0);
    op(K_TL, 4, 32'h4001, 32'h44);
    op(K_ST, 0, 32'h4001, 32'hD);
    mem_chk("R9 set mismatch", 1, 1, 32'h4001, 32'hD);
    rd_chk("R9", 4, 32'h44, 20, 32'h5);
    op(K_ST, 0, 32'h7000, 32'hE);
    mem_chk("R7", 1, 1, 32'h7000, 32'hE);
  endtask

  task automatic t_displace();          // R10
    op(K_TL, 1, 32'h5001, 32'h11);
    op(K_ST, 0, 32'h5001, 32'h22);
    op(K_TL, 9, 32'h5001, 32'h33);
    mem_chk("R10", 1, 1, 32'h5001, 32'h22);
    op(K_LD, 0, 32'h5001, 0);
    chk("R10", "ld_hit", ld_hit, 1);
    chk("R10", "ld_data", ld_data, 32'h33);
    op(K_TS, 1, 0, 0);
    mem_chk("R10 old released", 0, 0, 0, 0);
    op(K_TS, 9, 0, 0);
    mem_chk("R10 new clean", 0, 0, 0, 0);
  endtask

  task automatic t_portdirty();         // R11
    op(K_TL, 10, 32'h6002, 32'h1);
    wr(10, 32'h55);
    op(K_TS, 10, 0, 0);
    mem_chk("R11", 1, 1, 32'h6002, 32'h55);
  endtask

  initial begin
    #(5.0 * 20000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; fwd_mode = 1'b1; op_en = 1'b0; op_kind = 2'd0; op_reg = '0;
    op_addr = '0; op_data = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_regport();
    t_forward();
    t_trap();
    t_nobind();
    t_displace();
    t_portdirty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule